// File: doc/BRIEF.md
# Command-framed SPI register slave

This block is the serial front end of a small control register bank. An SPI master selects it by pulling the active-low chip select low. It then clocks in a 24-bit frame: an 8-bit command followed by 16 data bits. Command bit 7 chooses the direction (1 = read, 0 = write), and command bits 6..0 give the register address. The master may send the frame as one continuous stream or as three bytes with pauses between them. Either serial clock idle level is accepted.

A write changes nothing while the frame is still arriving. It takes effect only when chip select rises after all 24 rising edges have been counted. If chip select rises any earlier, the frame is dropped and the interface returns to idle. On a read, the addressed register is captured at the 8th rising edge and shifted out on the falling edges that follow, most significant bit first.

The whole interface runs on one fast system clock. Serial clock, chip select and data in each pass through a two-stage synchroniser with edge detection, so the serial clock must stay below one quarter of the system clock rate.

Top module: `spi_cmd_regslave`

## Requirements
- R1: A frame is 24 bits taken on rising serial clock edges, MSB first: bits C7..C0, then D15..D0. C7=1 marks a read, C7=0 marks a write, and C6..C0 is the register address. Rising edges beyond the 24th are ignored.
- R2: A write frame is committed when chip select rises after exactly 24 rising edges. At that point `reg_wr_en` pulses high for one system clock with `reg_wr_addr`/`reg_wr_data` set to C6..C0/D15..D0, and the register takes the new value.
- R3: If chip select rises after fewer than 24 rising edges, the write is discarded: `reg_wr_en` does not pulse and no register changes.
- R4: On a read frame, the addressed register value is loaded at the 8th rising edge. D15 appears on `dout` after the next falling edge, and each later falling edge presents the next lower bit.
- R5: `dout_oe` is high only while a frame is open. It falls within 4 system clocks of chip select rising, and `dout` is 0 whenever `dout_oe` is low.
- R6: A read cut short by chip select rising before its 24th edge turns the output off and loses the data. The next frame is then handled normally.
- R7: Addresses at or above NUM_REGS (default 8) read back as 0, and writes to them produce no `reg_wr_en` pulse.
- R8: Results are the same for serial clock idle low or idle high, and with or without pauses between the three bytes.
- R9: After reset all registers hold 0, `dout_oe` and `dout` are 0, and `reg_wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from master |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from master |
| dout | output | 1 | Serial data to master, 0 when not enabled |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| reg_wr_en | output | 1 | One-cycle pulse when a write commits |
| reg_wr_addr | output | 7 | Address of the committed write |
| reg_wr_data | output | 16 | Data of the committed write |

## Verification
Every pin edge passes through two synchroniser stages and one edge-detect register before it changes internal state. A commit therefore shows on `reg_wr_en` about four system clocks after chip select rises. The bench counts pulses continuously and reads the result only 8 clocks after chip select is high. Each read bit reaches `dout` about four clocks after the falling serial edge, and the bench samples it at the end of the 8-clock half period, just before the next rising edge. The output-enable check waits the same 8 clocks after chip select rises.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
  localparam int CMD_W  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = CMD_W - 1;
  localparam int FRAME_W = CMD_W + DATA_W;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] raw);
    cmd_t c;
    c.rd   = raw[CMD_W-1];
    c.addr = raw[ADDR_W-1:0];
    return c;
  endfunction

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a, input int n);
    return int'(a) < n;
  endfunction
endpackage

// File: rtl/rs_edge_sync.sv
module rs_edge_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RESET_VAL;
        else if (s == 0) chain[s] <= async_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= RESET_VAL;
    else last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
  assign fall  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/rs_frame_ctrl.sv
module rs_frame_ctrl
  import spi_rs_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_rise,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               din_s,
  output logic               active,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               frame_full,
  output logic               cmd_ready,
  output cmd_t               cmd,
  output logic               commit,
  output logic [ADDR_W-1:0]  commit_addr,
  output logic [DATA_W-1:0]  commit_data
);
  logic [FRAME_W-1:0] sr;
  logic               take_bit;

  assign frame_full = (bit_cnt == CNT_W'(FRAME_W));
  assign take_bit   = active && sclk_rise && !frame_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_cnt <= '0;
      sr      <= '0;
    end else if (cs_fall) begin
      active  <= 1'b1;
      bit_cnt <= '0;
      sr      <= '0;
    end else if (cs_rise) begin
      active  <= 1'b0;
      bit_cnt <= '0;
    end else if (take_bit) begin
      sr      <= {sr[FRAME_W-2:0], din_s};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign cmd_ready   = take_bit && (bit_cnt == CNT_W'(CMD_W - 1));
  assign cmd         = decode_cmd({sr[CMD_W-2:0], din_s});
  assign commit      = cs_rise && active && frame_full && !sr[FRAME_W-1];
  assign commit_addr = sr[FRAME_W-2:DATA_W];
  assign commit_data = sr[DATA_W-1:0];
endmodule

// File: rtl/rs_dout_shift.sv
module rs_dout_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         sclk_fall,
  input  logic         enable,
  output logic         bit_out
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_out <= 1'b0;
    end else if (clear) begin
      sr      <= '0;
      bit_out <= 1'b0;
    end else if (load) begin
      sr <= load_data;
    end else if (sclk_fall && enable) begin
      bit_out <= sr[W-1];
      sr      <= {sr[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/rs_reg_bank.sv
module rs_reg_bank
  import spi_rs_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(i)) regs[i] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/spi_cmd_regslave.sv
module spi_cmd_regslave
  import spi_rs_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int NPIN  = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b010;

  logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  assign pin_raw = {din, cs_n, sclk};

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      rs_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(PIN_RST[p])) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_raw[p]),
        .level(pin_lvl[p]), .rise(pin_rise[p]), .fall(pin_fall[p])
      );
    end
  endgenerate

  logic sclk_rise_evt, sclk_fall_evt, cs_rise_evt, cs_fall_evt, din_s;
  assign sclk_rise_evt = pin_rise[0];
  assign sclk_fall_evt = pin_fall[0];
  assign cs_rise_evt   = pin_rise[1];
  assign cs_fall_evt   = pin_fall[1];
  assign din_s         = pin_lvl[2];

  logic              frame_open, frame_full, cmd_ready, commit;
  logic [CNT_W-1:0]  bit_cnt;
  cmd_t              cmd;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data, rd_data;
  logic              dout_bit, rd_load;

  rs_frame_ctrl #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise_evt),
    .cs_fall(cs_fall_evt), .cs_rise(cs_rise_evt), .din_s(din_s),
    .active(frame_open), .bit_cnt(bit_cnt), .frame_full(frame_full),
    .cmd_ready(cmd_ready), .cmd(cmd), .commit(commit),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= commit && addr_mapped(commit_addr, NUM_REGS);
      if (commit) begin
        reg_wr_addr <= commit_addr;
        reg_wr_data <= commit_data;
      end
    end
  end

  rs_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .rd_addr(cmd.addr), .rd_data(rd_data)
  );

  assign rd_load = cmd_ready && cmd.rd;

  rs_dout_shift #(.W(DATA_W)) u_dout (
    .clk(clk), .rst_n(rst_n), .clear(cs_fall_evt | cs_rise_evt),
    .load(rd_load), .load_data(rd_data), .sclk_fall(sclk_fall_evt),
    .enable(frame_open), .bit_out(dout_bit)
  );

  assign dout_oe = frame_open;
  assign dout    = frame_open & dout_bit;
endmodule

// File: rtl/spi_cmd_regslave_checks.sv
module spi_cmd_regslave_checks
  import spi_rs_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int CNT_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise_evt,
  input logic              frame_full,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              dout,
  input logic              dout_oe,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr
);
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= FRAME_W);

  p_commit_after_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(cs_rise_evt && frame_full));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_abort_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_evt && !frame_full) |=> !reg_wr_en);

  p_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |=> !dout_oe);

  p_dout_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);

  p_mapped_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> int'(reg_wr_addr) < NUM_REGS);
endmodule

bind spi_cmd_regslave spi_cmd_regslave_checks #(
  .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .cs_rise_evt(cs_rise_evt), .frame_full(frame_full),
  .bit_cnt(bit_cnt), .dout(dout), .dout_oe(dout_oe), .reg_wr_en(reg_wr_en),
  .reg_wr_addr(reg_wr_addr)
);

// File: tb/spi_cmd_regslave_bench.sv
module spi_cmd_regslave_bench;
  localparam int NREG = 8;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout, dout_oe, reg_wr_en;
  logic [6:0]  reg_wr_addr;
  logic [15:0] reg_wr_data;

  always #2.5 clk = ~clk;

  spi_cmd_regslave u_spi_cmd_regslave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
  );

  int checks = 0, fails = 0, pulses = 0;
  bit done = 1'b0;
  logic [6:0]  last_addr;
  logic [15:0] last_data;
  logic [15:0] model [NREG];

  always @(posedge clk) if (rst_n && reg_wr_en) begin
    pulses++;
    last_addr = reg_wr_addr;
    last_data = reg_wr_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mk_cmd(input bit rd, input int addr);
    return {rd, 7'(addr)};
  endfunction

  function automatic logic [15:0] expect_rd(input int addr);
    return (addr < NREG) ? model[addr] : 16'h0;
  endfunction

  // nrise rising edges (24 = full frame); returns bits seen before rises 9..24
  task automatic xfer(input logic [7:0] cmd, input logic [15:0] data, input int nrise,
                      input bit cpol, input bit gaps, output logic [15:0] rd);
    logic [23:0] frame;
    frame = {cmd, data};
    rd = '0;
    sclk = cpol;
    ticks(4);
    cs_n = 1'b0;
    ticks(HALF);
    for (int i = 0; i < nrise; i++) begin
      sclk = 1'b0;
      if (gaps && (i == 8 || i == 16)) ticks(3 * HALF);
      din = frame[23-i];
      ticks(HALF);
      if (i == 4) chk("R5 oe during frame", 32'(dout_oe), 32'd1);
      if (i >= 8) rd[23-i] = dout;
      sclk = 1'b1;
      ticks(HALF);
    end
    if (!cpol) sclk = 1'b0;
    ticks(HALF);
    cs_n = 1'b1;
    ticks(8);
    chk("R5 oe off after cs high", {30'd0, dout_oe, dout}, 32'd0);
  endtask

  task automatic do_write(input int addr, input logic [15:0] d, input bit cpol, input bit gaps);
    int p0;
    logic [15:0] unused;
    p0 = pulses;
    xfer(mk_cmd(1'b0, addr), d, 24, cpol, gaps, unused);
    if (addr < NREG) begin
      model[addr] = d;
      chk("R2 one commit pulse", 32'(pulses - p0), 32'd1);
      chk("R2 commit addr/data", {9'd0, last_addr, last_data}, {9'd0, 7'(addr), d});
    end else begin
      chk("R7 no pulse for unmapped", 32'(pulses - p0), 32'd0);
    end
  endtask

  task automatic do_read(input int addr, input bit cpol, input bit gaps, input string req);
    logic [15:0] got;
    xfer(mk_cmd(1'b1, addr), 16'hFFFF, 24, cpol, gaps, got);
    chk(req, 32'(got), 32'(expect_rd(addr)));
  endtask

  initial begin
    logic [15:0] junk;
    int p0;
    void'($urandom(32'd11));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    ticks(5);
    chk("R9 reset outputs", {29'd0, dout_oe, dout, reg_wr_en}, 32'd0);
    rst_n = 1'b1;
    ticks(5);
    do_read(3, 1'b0, 1'b0, "R9 register zero after reset");

    // R1/R4: MSB-first pattern, continuous and byte-paused, both idle levels (R8)
    do_write(2, 16'h8001, 1'b0, 1'b0);
    do_read(2, 1'b0, 1'b0, "R4 read MSB first");
    do_write(5, 16'hA55A, 1'b1, 1'b1);
    do_read(5, 1'b0, 1'b1, "R8 idle-high paused write read back");
    do_read(5, 1'b1, 1'b0, "R8 idle-high continuous read");
    do_write(7, 16'h1234, 1'b0, 1'b1);
    do_read(7, 1'b1, 1'b1, "R1 frame fields");

    // R3: early chip select rise discards the write
    p0 = pulses;
    xfer(mk_cmd(1'b0, 2), 16'hDEAD, 23, 1'b0, 1'b0, junk);
    chk("R3 no pulse on 23 edges", 32'(pulses - p0), 32'd0);
    do_read(2, 1'b0, 1'b0, "R3 register unchanged after 23 edges");
    xfer(mk_cmd(1'b0, 5), 16'hBEEF, 10, 1'b1, 1'b0, junk);
    chk("R3 no pulse on 10 edges", 32'(pulses - p0), 32'd0);
    do_read(5, 1'b1, 1'b0, "R3 register unchanged after 10 edges");

    // R6: cut-short read, then a normal frame
    xfer(mk_cmd(1'b1, 7), 16'h0, 15, 1'b0, 1'b0, junk);
    do_write(1, 16'h0F0F, 1'b0, 1'b0);
    do_read(1, 1'b0, 1'b0, "R6 frame after aborted read");

    // R7: unmapped addresses
    do_write(NREG + 4, 16'h7777, 1'b0, 1'b0);
    do_read(NREG + 4, 1'b0, 1'b0, "R7 unmapped reads zero");

    // random mix
    for (int n = 0; n < 30; n++) begin
      int a;
      bit cp, gp;
      a  = $urandom_range(0, NREG + 3);
      cp = 1'($urandom_range(0, 1));
      gp = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) do_write(a, 16'($urandom), cp, gp);
      else do_read(a, cp, gp, "R4 random read");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule